// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence controller of one private, direct-mapped cache in a small shared-bus multiprocessor. Every line carries a tag, a data word and one of three coherence states: Invalid, Shared or Modified. Processor reads and writes that the local state permits finish in one cycle without bus traffic. Every other access stalls the processor port and requests the shared bus. Once granted, the controller issues one of four bus commands: read, read-for-ownership, ownership upgrade or writeback.

In parallel the controller snoops every bus command issued by the other caches. A remote read of a locally Modified line forces the data out on the flush port and leaves the line Shared. A remote ownership request removes the local copy, after a flush if the copy was dirty. An arbiter and a backing store outside the block order the transactions one at a time and merge flushed data into the fill path. A conflict miss that would displace a dirty line first writes that line back; a clean victim is dropped silently.

Top module: `msi_cache_ctrl`

## Requirements
- R1: Each line holds exactly one state, encoded Invalid=0, Shared=1, Modified=2 on `lines_state[2i+1:2i]` (its tag on `lines_tag`); after reset every line is Invalid and the value 3 never appears.
- R2: A read whose line matches the tag in Shared or Modified raises `cpu_done` with the line data on the cycle after acceptance, with no bus request and no state change.
- R3: A read miss requests the bus with command read (code 0) for the request address; the line is filled with `bus_fill_data`, ends Shared, and `cpu_done` follows one cycle after `bus_done`.
- R4: A snooped read (code 0) that hits a local Modified line raises `flush_valid` with the line data on the next cycle and leaves the line Shared; a snooped read of a Shared line changes nothing and flushes nothing.
- R5: A write hitting a Modified line updates the data locally and completes the next cycle with no bus request.
- R6: A write to a Shared line with a matching tag issues an upgrade (code 2) and ends Modified holding the write data.
- R7: A write that misses issues read-for-ownership (code 1) and ends Modified holding the write data.
- R8: A snooped read-for-ownership or upgrade that hits a local Shared line makes it Invalid with no flush; a snooped read-for-ownership that hits a Modified line flushes it and makes it Invalid.
- R9: From acceptance of a missing access until its completion `cpu_ready` stays low; `cpu_ready` is also low in every cycle with `snp_valid`; after a grant `bus_req` drops for at least one cycle.
- R10: A miss that displaces a Modified line of another tag first issues a writeback (code 3) carrying the victim address and data, then the fill; displacing a Shared line issues only the fill.
- R11: Across caches on one bus, a line Modified in one cache is never valid with the same tag in another, and every read returns the value of the most recent completed write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller can accept an access this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data (valid with cpu_done) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; the command is on the bus this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_done | input | 1 | Transaction completion for this cache |
| bus_fill_data | input | DATA_W | Fill data returned with bus_done |
| snp_valid | input | 1 | A remote command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty data supplied for the previous snoop |
| flush_data | output | DATA_W | Flushed data |
| lines_state | output | 2*LINES | Per-line coherence state |
| lines_tag | output | TAG_W*LINES | Per-line tag |

## Verification
Hits are due on the cycle after the accepting edge, a miss completes one cycle after `bus_done`, and a flush appears on the cycle after the snooped command; the bench drives and samples on the falling edge so each of these lands at a fixed, countable point. Each access task counts falling edges from acceptance to `cpu_done`, requiring exactly one for hits and more for misses, and it reads the bus transaction log kept by the bus model to confirm which commands, and how many, a scenario produced. After every access the pairwise state rule is evaluated over all caches and read data is compared with a reference memory updated by completed writes, including a race where two sharers write the same line at once.

// File: rtl/msi_pkg.sv
// Shared types for the coherence controller: line states and bus command codes.
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/msi_snoop_logic.sv
// Snoop reaction for one line: next state and whether dirty data must be flushed.
// Assumes the caller has already compared the snooped tag with the line tag.
module msi_snoop_logic
    import msi_pkg::*;
(
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic       tag_eq,
    input  line_st_t   cur_st,
    output line_st_t   nxt_st,
    output logic       do_flush,
    output logic       do_update
);
    // Decide the reaction to a remote command on a valid matching line.
    always_comb begin
        nxt_st   = cur_st;
        do_flush = 1'b0;
        if (snp_valid && tag_eq && cur_st != ST_I) begin
            case (bus_cmd_t'(snp_cmd))
                CMD_RD: if (cur_st == ST_M) begin
                    nxt_st   = ST_S;
                    do_flush = 1'b1;
                end
                CMD_RDX: begin
                    do_flush = (cur_st == ST_M);
                    nxt_st   = ST_I;
                end
                CMD_UPGR: nxt_st = ST_I;
                default: ;
            endcase
        end
    end

    assign do_update = (nxt_st != cur_st);
endmodule

// File: rtl/msi_req_fsm.sv
// Processor-side request sequencer: optional writeback of a dirty victim,
// then one fill or upgrade transaction. Assumes one grant per request and
// that bus_done arrives for each granted transaction.
module msi_req_fsm
    import msi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       acc_done,
    input  logic       need_wb,
    input  logic       line_m,
    input  logic       upg_ok,
    input  logic       req_we,
    input  logic       bus_gnt,
    input  logic       bus_done,
    output logic       idle,
    output logic       in_wb,
    output logic       bus_req,
    output logic [1:0] bus_cmd,
    output logic       wb_issue,
    output logic       fill_done
);
    typedef enum logic [2:0] {F_IDLE, F_WB_REQ, F_WB_WAIT, F_FILL_REQ, F_FILL_WAIT} fsm_t;
    fsm_t st_q, st_d;

    // Next-state selection for the request sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            F_IDLE:      if (accept && !acc_done) st_d = need_wb ? F_WB_REQ : F_FILL_REQ;
            F_WB_REQ:    if (!line_m) st_d = F_FILL_REQ;
                         else if (bus_gnt) st_d = F_WB_WAIT;
            F_WB_WAIT:   if (bus_done) st_d = F_FILL_REQ;
            F_FILL_REQ:  if (bus_gnt) st_d = F_FILL_WAIT;
            F_FILL_WAIT: if (bus_done) st_d = F_IDLE;
            default:     st_d = F_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    // Command choice is made at grant time from the current line state.
    always_comb begin
        if (st_q == F_WB_REQ)  bus_cmd = CMD_WB;
        else if (!req_we)      bus_cmd = CMD_RD;
        else if (upg_ok)       bus_cmd = CMD_UPGR;
        else                   bus_cmd = CMD_RDX;
    end

    assign idle      = (st_q == F_IDLE);
    assign in_wb     = (st_q == F_WB_REQ);
    assign bus_req   = (in_wb && line_m) || (st_q == F_FILL_REQ);
    assign wb_issue  = in_wb && line_m && bus_gnt;
    assign fill_done = (st_q == F_FILL_WAIT) && bus_done;
endmodule

// File: rtl/msi_cache_ctrl.sv
// Per-cache MSI controller: direct-mapped line store, processor port,
// bus request side and snoop side. Assumes a bus that carries one transaction
// at a time and never snoops a cache with its own command.
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    output logic                   cpu_ready,
    output logic                   cpu_done,
    output logic [DATA_W-1:0]      cpu_rdata,
    output logic                   bus_req,
    input  logic                   bus_gnt,
    output logic [1:0]             bus_cmd,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_done,
    input  logic [DATA_W-1:0]      bus_fill_data,
    input  logic                   snp_valid,
    input  logic [1:0]             snp_cmd,
    input  logic [ADDR_W-1:0]      snp_addr,
    output logic                   flush_valid,
    output logic [DATA_W-1:0]      flush_data,
    output logic [2*LINES-1:0]     lines_state,
    output logic [TAG_W*LINES-1:0] lines_tag
);
    line_st_t          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic              r_we;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;

    logic idle, in_wb, wb_issue, fill_done, accept, acc_done;
    logic need_wb, upg_ok, hit, tag_eq;
    logic [IDX_W-1:0] look_idx, s_idx;
    logic [TAG_W-1:0] look_tag, s_tag;
    line_st_t ln_st, s_nxt;
    logic s_flush, s_upd;

    // Lookup port: the incoming address while idle, the held request otherwise.
    assign look_idx = idle ? cpu_addr[IDX_W-1:0]      : r_addr[IDX_W-1:0];
    assign look_tag = idle ? cpu_addr[ADDR_W-1:IDX_W] : r_addr[ADDR_W-1:IDX_W];
    assign ln_st    = st_q[look_idx];
    assign tag_eq   = (tag_q[look_idx] == look_tag);
    assign hit      = (ln_st != ST_I) && tag_eq;
    assign acc_done = hit && (!cpu_we || ln_st == ST_M);
    assign need_wb  = (ln_st == ST_M) && !tag_eq;
    assign upg_ok   = (ln_st == ST_S) && tag_eq;

    assign cpu_ready = idle && !snp_valid;
    assign accept    = cpu_req && cpu_ready;

    assign bus_addr  = in_wb ? {tag_q[look_idx], look_idx} : r_addr;
    assign bus_wdata = dat_q[look_idx];

    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_snoop_logic u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .tag_eq    (tag_q[s_idx] == s_tag),
        .cur_st    (st_q[s_idx]),
        .nxt_st    (s_nxt),
        .do_flush  (s_flush),
        .do_update (s_upd)
    );

    msi_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .acc_done  (acc_done),
        .need_wb   (need_wb),
        .line_m    (ln_st == ST_M),
        .upg_ok    (upg_ok),
        .req_we    (r_we),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .idle      (idle),
        .in_wb     (in_wb),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .wb_issue  (wb_issue),
        .fill_done (fill_done)
    );

    // Capture the accepted request for the bus sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_we    <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (accept) begin
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
        end
    end

    // Processor response: hits on the next cycle, misses after the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done <= (accept && acc_done) || fill_done;
            if (accept && acc_done)
                cpu_rdata <= cpu_we ? cpu_wdata : dat_q[look_idx];
            else if (fill_done)
                cpu_rdata <= r_we ? r_wdata : bus_fill_data;
        end
    end

    // Snoop flush output, one cycle after the remote command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_valid <= 1'b0;
            flush_data  <= '0;
        end else begin
            flush_valid <= s_flush;
            flush_data  <= dat_q[s_idx];
        end
    end

    // Line store updates; snoop and local updates never share a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            if (s_upd) st_q[s_idx] <= s_nxt;
            if (accept && acc_done && cpu_we) dat_q[look_idx] <= cpu_wdata;
            if (wb_issue) st_q[look_idx] <= ST_I;
            if (fill_done) begin
                st_q[look_idx]  <= r_we ? ST_M : ST_S;
                tag_q[look_idx] <= r_addr[ADDR_W-1:IDX_W];
                dat_q[look_idx] <= r_we ? r_wdata : bus_fill_data;
            end
        end
    end

    // Flatten the per-line view.
    for (genvar g = 0; g < LINES; g++) begin : g_view
        assign lines_state[2*g +: 2]       = st_q[g];
        assign lines_tag[TAG_W*g +: TAG_W] = tag_q[g];
    end
endmodule

// File: rtl/msi_cache_chk.sv
// Protocol checker for msi_cache_ctrl, attached by bind. Observes ports only.
module msi_cache_chk #(
    parameter int ADDR_W = 4,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req,
    input logic                   cpu_we,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   cpu_ready,
    input logic                   cpu_done,
    input logic                   bus_req,
    input logic                   bus_gnt,
    input logic                   snp_valid,
    input logic [1:0]             snp_cmd,
    input logic [ADDR_W-1:0]      snp_addr,
    input logic                   flush_valid,
    input logic [2*LINES-1:0]     lines_state,
    input logic [TAG_W*LINES-1:0] lines_tag
);
    logic [IDX_W-1:0] c_idx, s_idx, s_idx_q;
    logic [1:0] c_st, s_st;
    logic c_hit, s_hit;

    // Derive the lookups the properties need from the port view.
    always_comb begin
        c_idx = cpu_addr[IDX_W-1:0];
        s_idx = snp_addr[IDX_W-1:0];
        c_st  = lines_state[2*c_idx +: 2];
        s_st  = lines_state[2*s_idx +: 2];
        c_hit = (c_st != 2'd0) && (lines_tag[TAG_W*c_idx +: TAG_W] == cpu_addr[ADDR_W-1:IDX_W]);
        s_hit = (s_st != 2'd0) && (lines_tag[TAG_W*s_idx +: TAG_W] == snp_addr[ADDR_W-1:IDX_W]);
    end

    // Remember the snooped line for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) s_idx_q <= '0;
        else        s_idx_q <= s_idx;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_legal
        assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
            lines_state[2*g +: 2] != 2'd3);
    end

    assert_read_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && c_hit) |=> (cpu_done && !bus_req && $stable(lines_state)));

    assert_flush_after_snoop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(snp_valid));

    assert_read_on_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd0 && s_hit && s_st == 2'd2)
        |=> (flush_valid && lines_state[2*s_idx_q +: 2] == 2'd1));

    assert_ownership_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2) && s_hit)
        |=> (lines_state[2*s_idx_q +: 2] == 2'd0));

    assert_stall_while_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    assert_single_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);
endmodule

bind msi_cache_ctrl msi_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .flush_valid(flush_valid), .lines_state(lines_state), .lines_tag(lines_tag)
);

// File: tb/tb_msi_cache_ctrl.sv
`timescale 1ns/1ps
// Three controllers on a modelled shared bus with round-robin arbitration and
// a backing store; directed scenarios, one task each.
module tb_msi_cache_ctrl;
    localparam int AW = 4, DW = 8, LINES = 4, NC = 3;
    localparam int TW = AW - $clog2(LINES);

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NC-1:0] cpu_req = '0, cpu_we = '0, cpu_ready, cpu_done;
    logic [AW-1:0] cpu_addr [NC];
    logic [DW-1:0] cpu_wdata [NC], cpu_rdata [NC];
    logic [NC-1:0] bus_req, bus_gnt, bus_done, snp_valid, flush_valid;
    logic [1:0]    bus_cmd [NC], snp_cmd [NC];
    logic [AW-1:0] bus_addr [NC], snp_addr [NC];
    logic [DW-1:0] bus_wdata [NC], flush_data [NC], fill_data;
    logic [2*LINES-1:0]  ls [NC];
    logic [TW*LINES-1:0] lt [NC];

    for (genvar c = 0; c < NC; c++) begin : g_cache
        msi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(LINES)) dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[c]), .cpu_we(cpu_we[c]), .cpu_addr(cpu_addr[c]),
            .cpu_wdata(cpu_wdata[c]), .cpu_ready(cpu_ready[c]), .cpu_done(cpu_done[c]),
            .cpu_rdata(cpu_rdata[c]), .bus_req(bus_req[c]), .bus_gnt(bus_gnt[c]),
            .bus_cmd(bus_cmd[c]), .bus_addr(bus_addr[c]), .bus_wdata(bus_wdata[c]),
            .bus_done(bus_done[c]), .bus_fill_data(fill_data),
            .snp_valid(snp_valid[c]), .snp_cmd(snp_cmd[c]), .snp_addr(snp_addr[c]),
            .flush_valid(flush_valid[c]), .flush_data(flush_data[c]),
            .lines_state(ls[c]), .lines_tag(lt[c]));
    end

    // ---------------- bus model ----------------
    logic [DW-1:0] mem [16];
    logic busy;
    int owner_q, rr, gsel;
    logic [AW-1:0] addr_q;
    int txn_cnt, flush_cnt;
    logic [1:0]    log_cmd [256];
    logic [AW-1:0] log_addr [256];
    logic [DW-1:0] log_data [256];
    logic any_flush;
    logic [DW-1:0] fl_data;

    always_comb begin
        int gi;
        gi = -1;
        bus_gnt = '0;
        if (!busy)
            for (int k = 0; k < NC; k++)
                if (gi < 0 && bus_req[(rr + k) % NC]) gi = (rr + k) % NC;
        gsel = (gi < 0) ? 0 : gi;
        if (gi >= 0) bus_gnt[gsel] = 1'b1;
        any_flush = 1'b0;
        fl_data = '0;
        for (int j = 0; j < NC; j++) begin
            snp_valid[j] = (gi >= 0) && (j != gi);
            snp_cmd[j]   = bus_cmd[gsel];
            snp_addr[j]  = bus_addr[gsel];
            bus_done[j]  = busy && (owner_q == j);
            if (flush_valid[j]) begin any_flush = 1'b1; fl_data = flush_data[j]; end
        end
        fill_data = any_flush ? fl_data : mem[addr_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; rr <= 0; owner_q <= 0; addr_q <= '0;
            txn_cnt <= 0; flush_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= DW'(i * 7 + 3);
        end else begin
            busy <= |bus_gnt;
            if (|bus_gnt) begin
                owner_q <= gsel;
                addr_q  <= bus_addr[gsel];
                rr      <= (gsel + 1) % NC;
                log_cmd[txn_cnt % 256]  <= bus_cmd[gsel];
                log_addr[txn_cnt % 256] <= bus_addr[gsel];
                log_data[txn_cnt % 256] <= bus_wdata[gsel];
                txn_cnt <= txn_cnt + 1;
                if (bus_cmd[gsel] == 2'd3) mem[bus_addr[gsel]] <= bus_wdata[gsel];
            end
            if (busy && any_flush) begin
                mem[addr_q] <= fl_data;
                flush_cnt <= flush_cnt + 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [DW-1:0] ref_mem [16];

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int st(input int c, input int a);
        return int'(ls[c][2*(a % LINES) +: 2]);
    endfunction

    function automatic int tg(input int c, input int a);
        return int'(lt[c][TW*(a % LINES) +: TW]);
    endfunction

    // R11: pairwise state rule over every line of every cache pair.
    task automatic inv_check();
        int bad = 0;
        for (int i = 0; i < LINES; i++)
            for (int a = 0; a < NC; a++)
                for (int b = 0; b < NC; b++)
                    if (a != b && st(a, i) == 2 && st(b, i) != 0 && tg(a, i) == tg(b, i)) bad++;
        check("R11", "pairwise Modified exclusivity violations", bad, 0);
    endtask

    task automatic access(input int c, input bit we, input int a, input int d,
                          output int rd, output int lat);
        int guard = 0;
        @(negedge clk);
        cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = AW'(a); cpu_wdata[c] = DW'(d);
        while (!cpu_ready[c] && guard < 1000) begin @(negedge clk); guard++; end
        @(posedge clk); #1 cpu_req[c] = 1'b0;
        lat = 1;
        @(negedge clk);
        while (!cpu_done[c] && lat < 1000) begin lat++; @(negedge clk); end
        rd = int'(cpu_rdata[c]);
        if (we) ref_mem[a] = DW'(d);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        for (int c = 0; c < NC; c++)
            check("R1", "all lines Invalid after reset", int'(ls[c]), 0);
    endtask

    task automatic t_read_miss();
        int rd, lat, n0 = txn_cnt;
        access(0, 0, 5, 0, rd, lat);
        check("R3", "read miss data", rd, 8'h26);
        check("R3", "one bus command", txn_cnt - n0, 1);
        check("R3", "command is read", int'(log_cmd[n0 % 256]), 0);
        check("R3", "line Shared", st(0, 5), 1);
        check("R9", "miss stalls beyond one cycle", int'(lat > 2), 1);
        inv_check();
    endtask

    task automatic t_read_hit();
        int rd, lat, n0 = txn_cnt;
        access(0, 0, 5, 0, rd, lat);
        check("R2", "read hit latency", lat, 1);
        check("R2", "read hit data", rd, 8'h26);
        check("R2", "no bus traffic", txn_cnt - n0, 0);
        check("R2", "state unchanged", st(0, 5), 1);
    endtask

    task automatic t_upgrade();
        int rd, lat, n0;
        access(1, 0, 5, 0, rd, lat);
        check("R3", "second sharer data", rd, 8'h26);
        n0 = txn_cnt;
        access(0, 1, 5, 8'hAA, rd, lat);
        check("R6", "command is upgrade", int'(log_cmd[n0 % 256]), 2);
        check("R6", "writer Modified", st(0, 5), 2);
        check("R8", "sharer invalidated by upgrade", st(1, 5), 0);
        inv_check();
    endtask

    task automatic t_write_hit();
        int rd, lat, n0 = txn_cnt;
        access(0, 1, 5, 8'hBB, rd, lat);
        check("R5", "write hit latency", lat, 1);
        check("R5", "no bus traffic", txn_cnt - n0, 0);
        check("R5", "stays Modified", st(0, 5), 2);
    endtask

    task automatic t_snoop_read_dirty();
        int rd, lat, f0 = flush_cnt;
        access(1, 0, 5, 0, rd, lat);
        check("R4", "read gets dirty data", rd, int'(ref_mem[5]));
        check("R4", "one flush", flush_cnt - f0, 1);
        check("R4", "owner downgraded to Shared", st(0, 5), 1);
        check("R3", "reader Shared", st(1, 5), 1);
        inv_check();
    endtask

    task automatic t_write_miss();
        int rd, lat, n0 = txn_cnt, f0 = flush_cnt;
        access(2, 1, 5, 8'hCC, rd, lat);
        check("R7", "command is read-for-ownership", int'(log_cmd[n0 % 256]), 1);
        check("R7", "writer Modified", st(2, 5), 2);
        check("R8", "sharer 0 invalidated", st(0, 5), 0);
        check("R8", "sharer 1 invalidated", st(1, 5), 0);
        check("R8", "no flush from Shared", flush_cnt - f0, 0);
        inv_check();
    endtask

    task automatic t_rdx_on_dirty();
        int rd, lat, f0 = flush_cnt;
        access(0, 1, 5, 8'hDD, rd, lat);
        check("R8", "dirty owner flushed", flush_cnt - f0, 1);
        check("R8", "dirty owner Invalid", st(2, 5), 0);
        check("R7", "new owner Modified", st(0, 5), 2);
        inv_check();
    endtask

    task automatic t_dirty_evict();
        int rd, lat, n0 = txn_cnt, f0;
        access(0, 0, 9, 0, rd, lat);
        check("R10", "two commands", txn_cnt - n0, 2);
        check("R10", "first is writeback", int'(log_cmd[n0 % 256]), 3);
        check("R10", "writeback address", int'(log_addr[n0 % 256]), 5);
        check("R10", "writeback data", int'(log_data[n0 % 256]), 8'hDD);
        check("R10", "then read", int'(log_cmd[(n0 + 1) % 256]), 0);
        check("R3", "fill data", rd, 8'h42);
        check("R3", "new line Shared with tag 2", st(0, 9) * 16 + tg(0, 9), 16 + 2);
        f0 = flush_cnt;
        access(2, 0, 5, 0, rd, lat);
        check("R10", "written-back value read from memory", rd, 8'hDD);
        check("R10", "no flush needed", flush_cnt - f0, 0);
        check("R11", "read returns latest write", rd, int'(ref_mem[5]));
        inv_check();
    endtask

    task automatic t_clean_evict();
        int rd, lat, n0 = txn_cnt;
        access(0, 0, 13, 0, rd, lat);
        check("R10", "clean victim: single command", txn_cnt - n0, 1);
        check("R10", "clean victim: command is read", int'(log_cmd[n0 % 256]), 0);
        check("R3", "fill data", rd, 8'h5E);
    endtask

    task automatic t_shared_stays();
        int rd, lat, f0;
        access(0, 0, 12, 0, rd, lat);
        f0 = flush_cnt;
        access(1, 0, 12, 0, rd, lat);
        check("R4", "snooped read leaves Shared", st(0, 12), 1);
        check("R4", "no flush from Shared", flush_cnt - f0, 0);
        check("R3", "data", rd, 8'h57);
    endtask

    task automatic t_write_race();
        int rd, lat, win;
        access(0, 0, 6, 0, rd, lat);
        access(1, 0, 6, 0, rd, lat);
        fork
            begin int r, l; access(0, 1, 6, 8'h11, r, l); end
            begin int r, l; access(1, 1, 6, 8'h22, r, l); end
        join
        inv_check();
        check("R11", "exactly one writer Modified", int'(st(0, 6) == 2) + int'(st(1, 6) == 2), 1);
        check("R11", "the other Invalid", int'(st(0, 6) == 0) + int'(st(1, 6) == 0), 1);
        win = (st(0, 6) == 2) ? 8'h11 : 8'h22;
        ref_mem[6] = DW'(win);
        access(2, 0, 6, 0, rd, lat);
        check("R11", "race: read sees the last writer", rd, win);
        inv_check();
    endtask

    task automatic t_concurrent();
        int rd, lat;
        fork
            begin int r, l; access(0, 1, 2, 8'h33, r, l); end
            begin int r, l; access(1, 1, 3, 8'h44, r, l); end
            begin int r, l; access(2, 0, 7, 0, r, l);
                check("R3", "concurrent read data", r, 8'h34); end
        join
        inv_check();
        access(2, 0, 2, 0, rd, lat);
        check("R11", "read of remote write (addr 2)", rd, int'(ref_mem[2]));
        access(0, 0, 3, 0, rd, lat);
        check("R11", "read of remote write (addr 3)", rd, int'(ref_mem[3]));
        inv_check();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin cpu_addr[c] = '0; cpu_wdata[c] = '0; end
        for (int i = 0; i < 16; i++) ref_mem[i] = DW'(i * 7 + 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hit();
        t_upgrade();
        t_write_hit();
        t_snoop_read_dirty();
        t_write_miss();
        t_rdx_on_dirty();
        t_dirty_evict();
        t_clean_evict();
        t_shared_stays();
        t_write_race();
        t_concurrent();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule